// File: doc/BRIEF.md
# Configuration completion receiver

This block waits for the completion of a single outstanding configuration request. After it is armed, it watches a stream of 64-bit completion beats. Each beat carries a low and a high 32-bit word and start and end flags. The block takes the completion status from the beat that opens the packet and the data from the beat that closes it. It then reports one result: pass with read data, or fail.

A bounded wait covers lost completions. The wait is counted in poll intervals, and each interval is a parameterised number of clocks. When the last interval runs out with no closing beat, the request fails in the same way as a completion that carries a nonzero status. For reads, the returned dword is aligned to the access size and byte offset that were latched at arm time, so the caller receives the value already right-justified.

Top module: `cfg_cpl_rx`

## Requirements
- R1: A pulse on arm_i latches size_i and offset_i, starts a fresh wait, clears the packet-open flag and sets the held status to a nonzero default. Arming while a wait is running restarts that wait.
- R2: A beat is taken only while a wait is running and when the beat has a start flag, has an end flag, or follows an earlier start beat of the same packet. Any other beat has no effect on the result.
- R3: On a start beat, the status is the 3-bit field in bits 15:13 of beat_hi_i. A later beat with no start flag does not change the held status.
- R4: When an end beat is taken, done_o is high for exactly one cycle, starting on the cycle after that beat. ok_o is 1 only when the held status is zero. A beat that has both flags takes its status and its data from that same beat.
- R5: An end beat that arrives with no start beat since arm gives ok_o = 0.
- R6: With no end beat taken, done_o rises with ok_o = 0 exactly POLL_LIMIT*POLL_DIV cycles after the arm edge.
- R7: Size code 2'b00 (one byte) returns bits [8*offset+7 : 8*offset] of beat_lo_i, zero-extended.
- R8: Size code 2'b01 (two bytes) returns the 16-bit half of beat_lo_i chosen by offset[1], zero-extended. Size codes 2'b10 and 2'b11 (four bytes) return beat_lo_i unchanged.
- R9: When ok_o = 0, data_o reads zero. Outside a wait, done_o stays low whatever beats arrive.
- R10: An end beat taken in the last cycle of the wait wins over the timeout and gives a pass. A beat that arrives after the timeout result has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Start a fresh wait for a completion |
| size_i | input | 2 | Access size code, latched at arm |
| offset_i | input | 2 | Byte offset within the dword, latched at arm |
| beat_valid_i | input | 1 | Beat present this cycle |
| beat_sop_i | input | 1 | Beat opens a packet |
| beat_eop_i | input | 1 | Beat closes a packet |
| beat_lo_i | input | 32 | Low word of the beat (data) |
| beat_hi_i | input | 32 | High word of the beat (status in 15:13) |
| done_o | output | 1 | One-cycle result strobe |
| ok_o | output | 1 | Result passed |
| data_o | output | 32 | Aligned read data, zero on failure |

## Verification
Two events can fall in the same cycle: a closing beat, and the expiry of the final poll interval. The bench runs a small configuration and places the end beat exactly in the last cycle of the wait. It expects a pass in that case. It then repeats the run with the end beat one cycle later, where it expects the timeout failure and no second strobe. A start-and-end beat that arrives in a single cycle is also checked, so that status capture and the final result come from one beat.

// File: rtl/cpl_rx_pkg.sv
package cpl_rx_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_WORD2 = 2'b11
  } acc_size_e;

  localparam int unsigned STAT_W   = 3;
  localparam int unsigned STAT_LSB = 13;
  localparam logic [STAT_W-1:0] STAT_UNSEEN = 3'b001;
endpackage

// File: rtl/cpl_poll_timer.sv
module cpl_poll_timer #(
  parameter int unsigned POLL_DIV   = 1250,
  parameter int unsigned POLL_LIMIT = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned CNT_W = $clog2(POLL_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(POLL_LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  generate
    if (POLL_DIV > 1) begin : g_div
      localparam int unsigned DIV_W = $clog2(POLL_DIV);
      localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(POLL_DIV - 1);
      logic [DIV_W-1:0] div_q;
      assign tick = run_i && (div_q == DIV_LAST);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        div_q <= '0;
        else if (restart_i) div_q <= '0;
        else if (run_i)     div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
      end
    end else begin : g_nodiv
      assign tick = run_i;
    end
  endgenerate

  assign expire_o = tick && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (restart_i)                  cnt_q <= '0;
    else if (tick && cnt_q != CNT_LAST)  cnt_q <= cnt_q + 1'b1;
  end

  // R6: interval count never passes the limit while waiting
  a_r6_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= CNT_LAST);
endmodule

// File: rtl/cpl_beat_tracker.sv
module cpl_beat_tracker
  import cpl_rx_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          en_i,
  input  logic          valid_i,
  input  logic          sop_i,
  input  logic          eop_i,
  input  logic [DW-1:0] hi_i,
  output logic          hit_o,
  output logic          pass_o
);
  logic              open_q;
  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] stat_eff;
  logic              take;

  assign take     = en_i && valid_i && (sop_i || eop_i || open_q);
  assign stat_eff = (take && sop_i) ? hi_i[STAT_LSB +: STAT_W] : stat_q;
  assign hit_o    = take && eop_i;
  assign pass_o   = (stat_eff == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      stat_q <= STAT_UNSEEN;
    end else if (clear_i) begin
      open_q <= 1'b0;
      stat_q <= STAT_UNSEEN;
    end else if (take) begin
      open_q <= !eop_i;
      if (sop_i) stat_q <= hi_i[STAT_LSB +: STAT_W];
    end
  end

  // R2: a packet opens only on a start beat
  a_r2_open_needs_sop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_q) |-> $past(valid_i && sop_i));
  // R3: held status moves only on a start beat or a clear
  a_r3_stat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(stat_q) |-> $past(clear_i || (valid_i && sop_i)));
endmodule

// File: rtl/cpl_lane_align.sv
module cpl_lane_align
  import cpl_rx_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  acc_size_e     size_i,
  input  logic [1:0]    offset_i,
  input  logic [DW-1:0] word_i,
  output logic [DW-1:0] res_o
);
  localparam int unsigned HW = DW / 2;
  localparam int unsigned NB = DW / 8;

  logic [7:0]    lane [NB];
  logic [HW-1:0] half [2];

  genvar gi;
  generate
    for (gi = 0; gi < NB; gi++) begin : g_lane
      assign lane[gi] = word_i[8*gi +: 8];
    end
    for (gi = 0; gi < 2; gi++) begin : g_half
      assign half[gi] = word_i[HW*gi +: HW];
    end
  endgenerate

  always_comb begin
    unique case (size_i)
      SZ_BYTE: res_o = DW'(lane[offset_i]);
      SZ_HALF: res_o = DW'(half[offset_i[1]]);
      default: res_o = word_i;
    endcase
  end

  // R7: byte reads leave the upper lanes clear
  always_comb begin
    if (size_i == SZ_BYTE) a_r7_byte_zext: assert (res_o[DW-1:8] == '0);
  end
endmodule

// File: rtl/cfg_cpl_rx.sv
module cfg_cpl_rx
  import cpl_rx_pkg::*;
#(
  parameter int unsigned DW         = 32,
  parameter int unsigned POLL_DIV   = 1250,
  parameter int unsigned POLL_LIMIT = 500
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic [1:0]    size_i,
  input  logic [1:0]    offset_i,
  input  logic          beat_valid_i,
  input  logic          beat_sop_i,
  input  logic          beat_eop_i,
  input  logic [DW-1:0] beat_lo_i,
  input  logic [DW-1:0] beat_hi_i,
  output logic          done_o,
  output logic          ok_o,
  output logic [DW-1:0] data_o
);
  logic          busy_q;
  acc_size_e     size_q;
  logic [1:0]    off_q;
  logic          done_q, ok_q;
  logic [DW-1:0] data_q;

  logic          hit, pass, expire, finish, good;
  logic [DW-1:0] aligned;

  cpl_poll_timer #(.POLL_DIV(POLL_DIV), .POLL_LIMIT(POLL_LIMIT)) i_timer (
    .clk_i, .rst_ni,
    .restart_i (arm_i),
    .run_i     (busy_q),
    .expire_o  (expire)
  );

  cpl_beat_tracker #(.DW(DW)) i_track (
    .clk_i, .rst_ni,
    .clear_i (arm_i),
    .en_i    (busy_q && !arm_i),
    .valid_i (beat_valid_i),
    .sop_i   (beat_sop_i),
    .eop_i   (beat_eop_i),
    .hi_i    (beat_hi_i),
    .hit_o   (hit),
    .pass_o  (pass)
  );

  cpl_lane_align #(.DW(DW)) i_align (
    .size_i   (size_q),
    .offset_i (off_q),
    .word_i   (beat_lo_i),
    .res_o    (aligned)
  );

  assign finish = busy_q && !arm_i && (hit || expire);
  assign good   = hit && pass;  // closing beat wins over same-cycle expiry

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      size_q <= SZ_WORD;
      off_q  <= '0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
      data_q <= '0;
    end else begin
      done_q <= finish;
      ok_q   <= finish && good;
      data_q <= (finish && good) ? aligned : '0;
      if (arm_i) begin
        busy_q <= 1'b1;
        size_q <= acc_size_e'(size_i);
        off_q  <= offset_i;
      end else if (finish) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign done_o = done_q;
  assign ok_o   = ok_q;
  assign data_o = data_q;

  // R4: result strobe lasts one cycle
  a_r4_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R4: pass flag only with the strobe
  a_r4_ok_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_o |-> done_o);
  // R9: failure returns zero data
  a_r9_fail_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !ok_o) |-> data_o == '0);
  // R9: no result without a running wait
  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |=> !done_o);
  // R6: expiry ends the wait
  a_r6_expire_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && !arm_i) |=> (done_o && !busy_q));
endmodule

// File: tb/test_cfg_cpl_rx.sv
module test_cfg_cpl_rx;
  localparam int unsigned DIV = 4;
  localparam int unsigned LIM = 5;
  localparam int unsigned N   = DIV * LIM;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm = 1'b0;
  logic [1:0]  size = 2'b10, off = 2'b00;
  logic        bv = 1'b0, bs = 1'b0, be = 1'b0;
  logic [31:0] blo = '0, bhi = '0;
  logic        done, ok;
  logic [31:0] data;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  cfg_cpl_rx #(.DW(32), .POLL_DIV(DIV), .POLL_LIMIT(LIM)) i_cfg_cpl_rx (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .size_i(size), .offset_i(off),
    .beat_valid_i(bv), .beat_sop_i(bs), .beat_eop_i(be),
    .beat_lo_i(blo), .beat_hi_i(bhi),
    .done_o(done), .ok_o(ok), .data_o(data)
  );

  task automatic chk(input string req, input logic [33:0] act, input logic [33:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic arm_req(input logic [1:0] s, input logic [1:0] o);
    @(negedge clk); arm = 1'b1; size = s; off = o;
    @(negedge clk); arm = 1'b0;
  endtask

  task automatic beat(input logic s, input logic e, input logic [31:0] hi, input logic [31:0] lo);
    bv = 1'b1; bs = s; be = e; bhi = hi; blo = lo;
    @(negedge clk); bv = 1'b0; bs = 1'b0; be = 1'b0; bhi = '0; blo = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] expect_rd(input logic [1:0] s, input logic [1:0] o, input logic [31:0] w);
    if (s == 2'b00) return (w / (32'd1 << (8 * o))) % 32'd256;
    if (s == 2'b01) return (w / (32'd1 << (16 * o[1]))) % 32'd65536;
    return w;
  endfunction

  function automatic logic [31:0] st_hi(input int st);
    return 32'(st) * 32'h2000;
  endfunction

  logic [31:0] pats [3] = '{32'hA1B2C3D4, 32'h80FF017E, 32'h5A00C3FF};

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(2);
    chk("R9 reset", {done, ok, data}, 34'h0);
    rst_n = 1'b1;
    idle(2);

    // R9: beats with no wait running
    beat(1'b1, 1'b1, 32'h0, 32'h1234);
    chk("R9 idle beat", {done, ok}, 2'b00);
    idle(3);
    chk("R9 idle later", {done, ok}, 2'b00);

    // R7 R8: size/offset sweep, two-beat packets
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 4; o++)
        for (int p = 0; p < 3; p++) begin
          arm_req(2'(s), 2'(o));
          beat(1'b1, 1'b0, st_hi(0), 32'hDEAD0000);
          beat(1'b0, 1'b1, 32'hFFFFFFFF, pats[p]);
          chk(s == 0 ? "R7 byte" : "R8 half/word", {done, ok, data},
              {2'b11, expect_rd(2'(s), 2'(o), pats[p])});
          @(negedge clk);
          chk("R4 pulse", {1'b0, done}, 2'b00);
        end

    // R3 R4: status sweep, single beat with both flags
    for (int st = 0; st < 8; st++) begin
      arm_req(2'b10, 2'b00);
      beat(1'b1, 1'b1, st_hi(st) | 32'h1FFF, 32'hCAFEF00D);
      chk("R4 status", {done, ok, data}, {1'b1, st == 0, st == 0 ? 32'hCAFEF00D : 32'h0});
    end

    // R3: middle beat with nonzero status bits does not recapture
    arm_req(2'b10, 2'b00);
    beat(1'b1, 1'b0, st_hi(0), 32'h0);
    beat(1'b0, 1'b0, st_hi(7), 32'h0);
    beat(1'b0, 1'b1, st_hi(5), 32'h11223344);
    chk("R3 hold", {done, ok, data}, {2'b11, 32'h11223344});

    // R2: flagless beat before any start is ignored; R5 end with no start
    arm_req(2'b10, 2'b00);
    beat(1'b0, 1'b0, st_hi(0), 32'h55);
    chk("R2 ignored", {done, ok}, 2'b00);
    beat(1'b0, 1'b1, st_hi(0), 32'h77);
    chk("R5 no sop", {done, ok, data}, {2'b10, 32'h0});

    // R1: rearm clears a bad captured status and open flag
    arm_req(2'b10, 2'b00);
    beat(1'b1, 1'b0, st_hi(2), 32'h0);
    arm_req(2'b00, 2'b11);
    beat(1'b1, 1'b0, st_hi(0), 32'h0);
    beat(1'b0, 1'b1, 32'h0, 32'hAB000000);
    chk("R1 rearm", {done, ok, data}, {2'b11, 32'h000000AB});
    arm_req(2'b10, 2'b00);
    beat(1'b1, 1'b0, st_hi(0), 32'h0);
    arm_req(2'b10, 2'b00);
    beat(1'b0, 1'b1, st_hi(0), 32'h9);
    chk("R1 open cleared", {done, ok, data}, {2'b10, 32'h0});

    // R6: timeout timing
    arm_req(2'b10, 2'b00);
    idle(N - 1);
    chk("R6 before", {1'b0, done}, 2'b00);
    @(negedge clk);
    chk("R6 expire", {done, ok, data}, {2'b10, 32'h0});

    // R10: end beat in final cycle wins
    arm_req(2'b10, 2'b00);
    beat(1'b1, 1'b0, st_hi(0), 32'h0);
    idle(N - 2);
    beat(1'b0, 1'b1, 32'h0, 32'h600D600D);
    chk("R10 last cycle", {done, ok, data}, {2'b11, 32'h600D600D});

    // R10: end beat one cycle late is ignored
    arm_req(2'b10, 2'b00);
    beat(1'b1, 1'b0, st_hi(0), 32'h0);
    idle(N - 1);
    chk("R10 timed out", {done, ok}, 2'b10);
    beat(1'b0, 1'b1, 32'h0, 32'h1);
    chk("R10 late ignored", {done, ok}, 2'b00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule